// File: doc/BRIEF.md
# Pulse Phase Width Meter

This block measures how long a digital input stays high and how long it stays low. When the enable input is set, the raw pin passes through a synchronizer. Edge detection then follows the synchronized level. Two saturating counters are gated by that level. The high-phase counter runs while the level is high and the low-phase counter runs while it is low. Each counter restarts at the start of its own phase. Each counter holds its value while the opposite phase is in progress.

At the edge that closes a phase, the count of the phase that just ended is copied into a capture register, so software can read both widths at leisure. A rising edge and a falling edge each pulse their own interrupt line for one clock. Clearing the enable input silences the interrupts and holds both live counters at zero. The capture registers keep their last values while the block is disabled.

Top module: `pulse_phase_meter`

## Requirements
- R1: After reset, every output is zero.
- R2: With enable set, `rise_irq` is high for exactly one clock per rising edge of the synchronized input, and never on two consecutive clocks.
- R3: With enable set, `fall_irq` is high for exactly one clock per falling edge of the synchronized input, and never in the same clock as `rise_irq`.
- R4: `hi_cnt` becomes 1 on the clock edge that follows a rising-edge cycle. It then increments by one for each further clock in which the synchronized input is high.
- R5: `lo_cnt` becomes 1 on the clock edge that follows a falling-edge cycle. It then increments by one for each further clock in which the synchronized input is low.
- R6: On the clock edge that follows a falling-edge cycle, `hi_width` takes the value `hi_cnt` held in that cycle. On the clock edge that follows a rising-edge cycle, `lo_width` takes the value `lo_cnt` held in that cycle. A pin held at one level for N sampling clocks therefore yields a captured width of N.
- R7: Neither counter wraps. Once a counter reaches all ones (2^W-1), it stays at that value for as long as its phase lasts.
- R8: While enable is low, both interrupts stay low, both counters read zero from the next clock on, and both capture registers keep their values.
- R9: While the input is in one phase, the counter of the other phase holds its last value.
- R10: The pin is sampled through a two-stage synchronizer. A change on the pin before clock edge k appears as an interrupt in the cycle after edge k+1, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Unit enable |
| pin_in | input | 1 | Raw, unsynchronized pulse input |
| hi_cnt | output | W | Live high-phase counter |
| lo_cnt | output | W | Live low-phase counter |
| hi_width | output | W | Captured width of the last high phase |
| lo_width | output | W | Captured width of the last low phase |
| rise_irq | output | 1 | One-clock pulse on a rising edge |
| fall_irq | output | 1 | One-clock pulse on a falling edge |

## Verification
The assertions check the following on every cycle: that each interrupt lasts one clock and the two never coincide, that a counter restarts at one after its opening edge, that the capture register takes the live count at the closing edge, that a counter holds at all ones, and that the disabled state leaves the counters at zero and the captures stable. Some behaviours can only be shown by the bench's scenarios against its reference model. These are the exact two-clock synchronizer latency, the captured width equal to the number of pin samples, the hold of the idle counter across a whole opposite phase, and saturation after a long pulse.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;

    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_info_t;

endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync
    import pwm_meas_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    output edge_info_t edge_o
);

    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (STAGES > 1) begin
            st_d.chain = {st_q.chain[STAGES-2:0], pin_in};
        end else begin
            st_d.chain[0] = pin_in;
        end
        st_d.prev = st_q.chain[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_o.level = st_q.chain[TOP];
    assign edge_o.rise  = st_q.chain[TOP] & ~st_q.prev;
    assign edge_o.fall  = ~st_q.chain[TOP] & st_q.prev;

endmodule

// File: rtl/phase_counter.sv
module phase_counter
    import pwm_meas_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter logic        ACTIVE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  edge_info_t   edge_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] width_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cap;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       in_phase;
    logic       opens;
    logic       closes;

    always_comb begin
        in_phase = (edge_i.level == ACTIVE);
        opens    = ACTIVE ? edge_i.rise : edge_i.fall;
        closes   = ACTIVE ? edge_i.fall : edge_i.rise;
        st_d     = st_q;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (in_phase) begin
            if (opens) begin
                st_d.cnt = CNT_ONE;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end else if (closes) begin
            st_d.cap = st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign width_o = st_q.cap;

endmodule

// File: rtl/pulse_phase_meter.sv
module pulse_phase_meter
    import pwm_meas_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         pin_in,
    output logic [W-1:0] hi_cnt,
    output logic [W-1:0] lo_cnt,
    output logic [W-1:0] hi_width,
    output logic [W-1:0] lo_width,
    output logic         rise_irq,
    output logic         fall_irq
);

    localparam int unsigned PHASES = 2;

    edge_info_t   edge_w;
    logic [W-1:0] cnt_w [PHASES];
    logic [W-1:0] cap_w [PHASES];

    pin_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .edge_o (edge_w)
    );

    for (genvar gi = 0; gi < PHASES; gi++) begin : g_phase
        phase_counter #(
            .W      (W),
            .ACTIVE (gi[0])
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (enable),
            .edge_i  (edge_w),
            .count_o (cnt_w[gi]),
            .width_o (cap_w[gi])
        );
    end

    assign lo_cnt   = cnt_w[0];
    assign hi_cnt   = cnt_w[1];
    assign lo_width = cap_w[0];
    assign hi_width = cap_w[1];
    assign rise_irq = enable & edge_w.rise;
    assign fall_irq = enable & edge_w.fall;

endmodule

// File: rtl/pulse_phase_meter_chk.sv
module pulse_phase_meter_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic [W-1:0] hi_cnt,
    input logic [W-1:0] lo_cnt,
    input logic [W-1:0] hi_width,
    input logic [W-1:0] lo_width,
    input logic         rise_irq,
    input logic         fall_irq
);

    localparam logic [W-1:0] TOPV = {W{1'b1}};

    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_irq |=> !rise_irq);

    // R3
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_irq |=> !fall_irq);

    // R3
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_irq && fall_irq));

    // R4
    hi_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_irq |=> (hi_cnt == 1));

    // R5
    lo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_irq |=> (lo_cnt == 1));

    // R6
    hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_irq |=> (hi_width == $past(hi_cnt)));

    // R6
    lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_irq |=> (lo_width == $past(lo_cnt)));

    // R7
    hi_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && hi_cnt == TOPV && !rise_irq) |=> (!enable || hi_cnt == TOPV)
        || (hi_cnt == TOPV));

    // R7
    lo_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && lo_cnt == TOPV && !fall_irq) |=> (lo_cnt == TOPV));

    // R8
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (hi_cnt == 0 && lo_cnt == 0));

    // R8
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(hi_width) && $stable(lo_width)));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!rise_irq && !fall_irq));

endmodule

bind pulse_phase_meter pulse_phase_meter_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .hi_cnt   (hi_cnt),
    .lo_cnt   (lo_cnt),
    .hi_width (hi_width),
    .lo_width (lo_width),
    .rise_irq (rise_irq),
    .fall_irq (fall_irq)
);

// File: tb/pulse_phase_meter_bench.sv
module pulse_phase_meter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int MAXV       = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         pin_in = 1'b0;
    logic [W-1:0] hi_cnt, lo_cnt, hi_width, lo_width;
    logic         rise_irq, fall_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // reference model state
    int  m_s1 = 0, m_s2 = 0, m_prev = 0;
    int  m_hc = 0, m_lc = 0, m_hw = 0, m_lw = 0;
    bit  model_on = 1'b0;
    int  seed = 12345;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_phase_meter #(.W(W)) u_pulse_phase_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .pin_in   (pin_in),
        .hi_cnt   (hi_cnt),
        .lo_cnt   (lo_cnt),
        .hi_width (hi_width),
        .lo_width (lo_width),
        .rise_irq (rise_irq),
        .fall_irq (fall_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int er, ef;
        er = (enable && m_s2 == 1 && m_prev == 0) ? 1 : 0;
        ef = (enable && m_s2 == 0 && m_prev == 1) ? 1 : 0;
        check(int'(rise_irq) == er, "R2 rise_irq", int'(rise_irq), er);
        check(int'(fall_irq) == ef, "R3 fall_irq", int'(fall_irq), ef);
        check(int'(hi_cnt) == m_hc, "R4 hi_cnt", int'(hi_cnt), m_hc);
        check(int'(lo_cnt) == m_lc, "R5 lo_cnt", int'(lo_cnt), m_lc);
        check(int'(hi_width) == m_hw, "R6 hi_width", int'(hi_width), m_hw);
        check(int'(lo_width) == m_lw, "R6 lo_width", int'(lo_width), m_lw);
    endtask

    task automatic model_advance();
        int lvl, r, f;
        lvl = m_s2;
        r = (m_s2 == 1 && m_prev == 0) ? 1 : 0;
        f = (m_s2 == 0 && m_prev == 1) ? 1 : 0;
        if (!enable) begin
            m_hc = 0;
            m_lc = 0;
        end else if (lvl == 1) begin
            m_hc = r ? 1 : ((m_hc < MAXV) ? m_hc + 1 : MAXV);
            if (r) m_lw = m_lc;
        end else begin
            m_lc = f ? 1 : ((m_lc < MAXV) ? m_lc + 1 : MAXV);
            if (f) m_hw = m_hc;
        end
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = int'(pin_in);
    endtask

    task automatic tick(input bit en_v, input bit pin_v);
        @(negedge clk);
        if (model_on) compare_all();
        enable = en_v;
        pin_in = pin_v;
        if (model_on) model_advance();
    endtask

    task automatic hold(input bit en_v, input bit pin_v, input int n);
        for (int i = 0; i < n; i++) tick(en_v, pin_v);
    endtask

    initial begin
        int keep_hw, keep_lw;
        bit lvl;
        hold(0, 0, 3);
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        // R1: reset state
        check(hi_cnt == 0 && lo_cnt == 0, "R1 counters", int'(hi_cnt) + int'(lo_cnt), 0);
        check(hi_width == 0 && lo_width == 0, "R1 widths", int'(hi_width) + int'(lo_width), 0);
        check(!rise_irq && !fall_irq, "R1 irqs", int'(rise_irq) + int'(fall_irq), 0);

        hold(1, 0, 10);
        // R10: two-stage latency on a rising pin
        tick(1, 1);
        tick(1, 1);
        check(rise_irq == 1'b0, "R10 early", int'(rise_irq), 0);
        tick(1, 1);
        check(rise_irq == 1'b1, "R10 arrival", int'(rise_irq), 1);
        hold(1, 1, 4);   // seven high samples in total
        hold(1, 0, 5);
        hold(1, 1, 4);
        hold(1, 0, 2);
        // R6: widths equal sample counts
        check(hi_width == 7, "R6 high width", int'(hi_width), 7);
        check(lo_width == 5, "R6 low width", int'(lo_width), 5);
        hold(1, 0, 6);
        check(hi_width == 4, "R6 second high width", int'(hi_width), 4);

        // R7: long high pulse saturates
        hold(1, 1, 300);
        check(hi_cnt == MAXV, "R7 hi saturate", int'(hi_cnt), MAXV);
        hold(1, 0, 10);
        // R9: idle counter holds
        check(hi_cnt == MAXV, "R9 hi hold", int'(hi_cnt), MAXV);
        check(hi_width == MAXV, "R7 captured max", int'(hi_width), MAXV);
        hold(1, 0, 300);
        check(lo_cnt == MAXV, "R7 lo saturate", int'(lo_cnt), MAXV);
        hold(1, 1, 6);
        check(lo_cnt == MAXV, "R9 lo hold", int'(lo_cnt), MAXV);

        // R8: disabled unit
        keep_hw = int'(hi_width);
        keep_lw = int'(lo_width);
        tick(0, 0);
        for (int i = 0; i < 20; i++) begin
            tick(0, i[1]);
            check(hi_cnt == 0 && lo_cnt == 0, "R8 counters zero", int'(hi_cnt) + int'(lo_cnt), 0);
            check(!rise_irq && !fall_irq, "R8 irqs quiet", int'(rise_irq) + int'(fall_irq), 0);
            check(int'(hi_width) == keep_hw, "R8 hi_width held", int'(hi_width), keep_hw);
            check(int'(lo_width) == keep_lw, "R8 lo_width held", int'(lo_width), keep_lw);
        end

        // mixed traffic against the reference model
        lvl = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            seed = seed * 1103515245 + 12345;
            if (((seed >>> 16) & 7) == 0) lvl = ~lvl;
            tick(((seed >>> 20) & 63) != 0, lvl);
        end
        hold(1, 0, 5);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule